// File: doc/BRIEF.md
# ECC Event Reporter with Per-Source Capture

This block collects error-correction events from two memory sources, an on-chip RAM and a flash array. Each source signals two kinds of event: a corrected single-bit error and an uncorrectable error. Each kind arrives as a one-cycle pulse together with a packed information word that holds the faulting address, bus attributes, requesting master number and data. Software chooses which of the four source/class combinations are reported by setting an 8-bit configuration byte on a small register bus.

An event whose class is enabled does three things. It sets a sticky status flag, it raises the interrupt request, and it loads that source's capture bank with the event's information. Software reads the capture banks back over the same bus. Status flags clear when 1 is written to them. Independent of any enable, every uncorrectable event produces a bus error response on the cycle after it, because the access that hit it must always terminate with an error.

Top module: `ecc_event_reporter`

## Requirements
- R1: The configuration register at address 0 stores only bits 7:4. Reads return 0 in bits 3:0 and 31:8, and writes to those bits have no effect.
- R2: After reset the configuration, the status flags, both capture banks, `irq` and both error responses are all 0.
- R3: Configuration bit 4 enables RAM single-bit events, bit 5 flash single-bit, bit 6 RAM uncorrectable and bit 7 flash uncorrectable. An enabled event sets its status flag at address 1 (bit 0 RAM single-bit, bit 1 flash single-bit, bit 2 RAM uncorrectable, bit 3 flash uncorrectable). The flag reads as 1 from the cycle after the event pulse.
- R4: An event whose class is disabled sets no flag, raises no interrupt and leaves both capture banks unchanged.
- R5: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If an enabled event arrives in the same cycle as the clear of its flag, the flag ends up set.
- R6: `irq` is high exactly when at least one status flag is set, and it stays high until every flag has been cleared.
- R7: An enabled event loads its own source's capture bank from its information word, laid out as {address[75:44], attributes[43:36], master[35:32], data[31:0]}. The RAM bank reads at address 2 (address), address 3 ({master in bits 11:8, attributes in bits 7:0}) and address 4 (data). The flash bank reads at addresses 5, 6 and 7 with the same layout.
- R8: Enabled events on both sources in the same cycle load both banks independently. If both classes hit one source in the same cycle and both are enabled, that source captures the uncorrectable event's word. If only one of the two is enabled, it captures the enabled one's word.
- R9: A later enabled event on a source overwrites that source's capture bank.
- R10: Every uncorrectable event pulse produces a one-cycle error response for its source (`ram_err_rsp` or `flash_err_rsp`) on the following cycle, whether or not its class is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` (combinational) |
| ram_sb_evt | input | 1 | RAM single-bit correction pulse |
| ram_sb_info | input | 76 | Information word for the RAM single-bit event |
| ram_nc_evt | input | 1 | RAM uncorrectable error pulse |
| ram_nc_info | input | 76 | Information word for the RAM uncorrectable event |
| flash_sb_evt | input | 1 | Flash single-bit correction pulse |
| flash_sb_info | input | 76 | Information word for the flash single-bit event |
| flash_nc_evt | input | 1 | Flash uncorrectable error pulse |
| flash_nc_info | input | 76 | Information word for the flash uncorrectable event |
| irq | output | 1 | ECC interrupt request |
| ram_err_rsp | output | 1 | Error response for the RAM access |
| flash_err_rsp | output | 1 | Error response for the flash access |

## Verification
The assertions check on every cycle that an enabled event sets its flag and that the interrupt never rises without an enabled event. They also check that the interrupt and an uncleared flag hold, that a bank with no enabled event keeps its contents, and that the error response follows every uncorrectable pulse. Some behaviour can only be shown by the bench's scenarios. These are the exact flag pattern and captured word for every combination of the four enables and four event inputs, the choice of word when both classes hit one source, the priority of a set over a clear in the same cycle, and overwriting by a later event.

// File: rtl/ecc_rpt_pkg.sv
package ecc_rpt_pkg;
    localparam int ECC_AW   = 32;
    localparam int ECC_ATW  = 8;
    localparam int ECC_MW   = 4;
    localparam int ECC_DW   = 32;
    localparam int BUS_W    = 32;
    localparam int REG_AW   = 3;
    localparam int NSRC     = 2;
    localparam int STAT_W   = 2 * NSRC;
    localparam int CAP_REGS = 3;

    localparam int CFG_SB_LSB = 4;
    localparam int CFG_NC_LSB = CFG_SB_LSB + NSRC;

    localparam logic [REG_AW-1:0] RA_CFG  = REG_AW'(0);
    localparam logic [REG_AW-1:0] RA_STAT = REG_AW'(1);
    localparam int RA_CAP_BASE = 2;

    typedef struct packed {
        logic [ECC_AW-1:0]  addr;
        logic [ECC_ATW-1:0] attr;
        logic [ECC_MW-1:0]  mst;
        logic [ECC_DW-1:0]  data;
    } ecc_info_t;

    localparam int INFO_W = $bits(ecc_info_t);
endpackage

// File: rtl/ecc_ctl_regs.sv
module ecc_ctl_regs
    import ecc_rpt_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [REG_AW-1:0]        addr,
    input  logic [7:0]               wdata,
    input  logic [NSRC-1:0]          sb_evt,
    input  logic [NSRC-1:0]          nc_evt,
    output logic [NSRC-1:0]          sb_en_q,
    output logic [NSRC-1:0]          nc_en_q,
    output logic [STAT_W-1:0]        stat_q
);
    typedef struct packed {
        logic [NSRC-1:0]   sb_en;
        logic [NSRC-1:0]   nc_en;
        logic [STAT_W-1:0] stat;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_en && addr == RA_CFG) begin
            ctl_d.sb_en = wdata[CFG_SB_LSB +: NSRC];
            ctl_d.nc_en = wdata[CFG_NC_LSB +: NSRC];
        end
        if (wr_en && addr == RA_STAT) begin
            ctl_d.stat = ctl_q.stat & ~wdata[STAT_W-1:0];
        end
        // New events take priority over a clear in the same cycle.
        for (int s = 0; s < NSRC; s++) begin
            if (sb_evt[s] && ctl_q.sb_en[s]) ctl_d.stat[s] = 1'b1;
            if (nc_evt[s] && ctl_q.nc_en[s]) ctl_d.stat[NSRC+s] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign sb_en_q = ctl_q.sb_en;
    assign nc_en_q = ctl_q.nc_en;
    assign stat_q  = ctl_q.stat;
endmodule

// File: rtl/ecc_capture_bank.sv
module ecc_capture_bank
    import ecc_rpt_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sb_evt,
    input  logic      nc_evt,
    input  logic      sb_en,
    input  logic      nc_en,
    input  ecc_info_t sb_info,
    input  ecc_info_t nc_info,
    output ecc_info_t cap_q,
    output logic      err_q
);
    typedef struct packed {
        ecc_info_t cap;
        logic      err;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d     = bank_q;
        // The access that saw an uncorrectable error is always terminated.
        bank_d.err = nc_evt;
        if (nc_evt && nc_en)      bank_d.cap = nc_info;
        else if (sb_evt && sb_en) bank_d.cap = sb_info;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign cap_q = bank_q.cap;
    assign err_q = bank_q.err;
endmodule

// File: rtl/ecc_rd_mux.sv
module ecc_rd_mux
    import ecc_rpt_pkg::*;
(
    input  logic [REG_AW-1:0] addr,
    input  logic [NSRC-1:0]   sb_en,
    input  logic [NSRC-1:0]   nc_en,
    input  logic [STAT_W-1:0] stat,
    input  ecc_info_t         caps [NSRC],
    output logic [BUS_W-1:0]  rdata
);
    always_comb begin
        rdata = '0;
        if (addr == RA_CFG) begin
            rdata[CFG_SB_LSB +: NSRC] = sb_en;
            rdata[CFG_NC_LSB +: NSRC] = nc_en;
        end
        if (addr == RA_STAT) rdata[STAT_W-1:0] = stat;
        for (int s = 0; s < NSRC; s++) begin
            if (addr == REG_AW'(RA_CAP_BASE + CAP_REGS * s))
                rdata[ECC_AW-1:0] = caps[s].addr;
            if (addr == REG_AW'(RA_CAP_BASE + CAP_REGS * s + 1))
                rdata[ECC_ATW+ECC_MW-1:0] = {caps[s].mst, caps[s].attr};
            if (addr == REG_AW'(RA_CAP_BASE + CAP_REGS * s + 2))
                rdata[ECC_DW-1:0] = caps[s].data;
        end
    end
endmodule

// File: rtl/ecc_event_reporter.sv
module ecc_event_reporter
    import ecc_rpt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              ram_sb_evt,
    input  logic [INFO_W-1:0] ram_sb_info,
    input  logic              ram_nc_evt,
    input  logic [INFO_W-1:0] ram_nc_info,
    input  logic              flash_sb_evt,
    input  logic [INFO_W-1:0] flash_sb_info,
    input  logic              flash_nc_evt,
    input  logic [INFO_W-1:0] flash_nc_info,
    output logic              irq,
    output logic              ram_err_rsp,
    output logic              flash_err_rsp
);
    logic [NSRC-1:0]   sb_evt, nc_evt, sb_en_q, nc_en_q, err_q;
    logic [STAT_W-1:0] stat_q;
    ecc_info_t         sb_info [NSRC];
    ecc_info_t         nc_info [NSRC];
    ecc_info_t         cap_q   [NSRC];

    assign sb_evt     = {flash_sb_evt, ram_sb_evt};
    assign nc_evt     = {flash_nc_evt, ram_nc_evt};
    assign sb_info[0] = ram_sb_info;
    assign sb_info[1] = flash_sb_info;
    assign nc_info[0] = ram_nc_info;
    assign nc_info[1] = flash_nc_info;

    ecc_ctl_regs u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata[7:0]),
        .sb_evt  (sb_evt),
        .nc_evt  (nc_evt),
        .sb_en_q (sb_en_q),
        .nc_en_q (nc_en_q),
        .stat_q  (stat_q)
    );

    for (genvar s = 0; s < NSRC; s++) begin : g_bank
        ecc_capture_bank u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .sb_evt  (sb_evt[s]),
            .nc_evt  (nc_evt[s]),
            .sb_en   (sb_en_q[s]),
            .nc_en   (nc_en_q[s]),
            .sb_info (sb_info[s]),
            .nc_info (nc_info[s]),
            .cap_q   (cap_q[s]),
            .err_q   (err_q[s])
        );
    end

    ecc_rd_mux u_rd (
        .addr  (bus_addr),
        .sb_en (sb_en_q),
        .nc_en (nc_en_q),
        .stat  (stat_q),
        .caps  (cap_q),
        .rdata (bus_rdata)
    );

    assign irq           = |stat_q;
    assign ram_err_rsp   = err_q[0];
    assign flash_err_rsp = err_q[1];
endmodule

// File: rtl/ecc_event_reporter_chk.sv
module ecc_event_reporter_chk
    import ecc_rpt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [REG_AW-1:0] bus_addr,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic [BUS_W-1:0]  bus_rdata,
    input logic              ram_sb_evt,
    input logic              ram_nc_evt,
    input logic              flash_sb_evt,
    input logic              flash_nc_evt,
    input logic              irq,
    input logic              ram_err_rsp,
    input logic              flash_err_rsp,
    input logic [NSRC-1:0]   sb_en,
    input logic [NSRC-1:0]   nc_en,
    input logic [STAT_W-1:0] stat,
    input ecc_info_t         ram_cap,
    input ecc_info_t         flash_cap
);
    logic ram_hit, flash_hit, any_hit;
    assign ram_hit   = (ram_sb_evt && sb_en[0]) || (ram_nc_evt && nc_en[0]);
    assign flash_hit = (flash_sb_evt && sb_en[1]) || (flash_nc_evt && nc_en[1]);
    assign any_hit   = ram_hit || flash_hit;

    a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr == RA_CFG |-> bus_rdata[3:0] == 4'b0 && bus_rdata[31:8] == 24'b0);

    a_r3_ram_sb_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ram_sb_evt && sb_en[0] |=> stat[0]);
    a_r3_flash_sb_flag: assert property (@(posedge clk) disable iff (!rst_n)
        flash_sb_evt && sb_en[1] |=> stat[1]);
    a_r3_ram_nc_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ram_nc_evt && nc_en[0] |=> stat[2]);
    a_r3_flash_nc_flag: assert property (@(posedge clk) disable iff (!rst_n)
        flash_nc_evt && nc_en[1] |=> stat[3]);

    a_r4_no_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !irq && !any_hit |=> !irq);

    a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        stat[0] && !(bus_wr && bus_addr == RA_STAT && bus_wdata[0]) |=> stat[0]);

    a_r6_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !bus_wr |=> irq);

    a_r4_ram_cap_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_hit |=> $stable(ram_cap));
    a_r4_flash_cap_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_hit |=> $stable(flash_cap));

    a_r10_ram_err: assert property (@(posedge clk) disable iff (!rst_n)
        ram_nc_evt |=> ram_err_rsp);
    a_r10_ram_err_off: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_nc_evt |=> !ram_err_rsp);
    a_r10_flash_err: assert property (@(posedge clk) disable iff (!rst_n)
        flash_nc_evt |=> flash_err_rsp);
    a_r10_flash_err_off: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_nc_evt |=> !flash_err_rsp);
endmodule

bind ecc_event_reporter ecc_event_reporter_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_wr        (bus_wr),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .ram_sb_evt    (ram_sb_evt),
    .ram_nc_evt    (ram_nc_evt),
    .flash_sb_evt  (flash_sb_evt),
    .flash_nc_evt  (flash_nc_evt),
    .irq           (irq),
    .ram_err_rsp   (ram_err_rsp),
    .flash_err_rsp (flash_err_rsp),
    .sb_en         (sb_en_q),
    .nc_en         (nc_en_q),
    .stat          (stat_q),
    .ram_cap       (cap_q[0]),
    .flash_cap     (cap_q[1])
);

// File: tb/tb_ecc_event_reporter.sv
module tb_ecc_event_reporter;
    import ecc_rpt_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0;
    logic [REG_AW-1:0] bus_addr = '0;
    logic [BUS_W-1:0]  bus_wdata = '0;
    logic [BUS_W-1:0]  bus_rdata;
    logic              ram_sb_evt = 1'b0, ram_nc_evt = 1'b0;
    logic              flash_sb_evt = 1'b0, flash_nc_evt = 1'b0;
    logic [INFO_W-1:0] ram_sb_info = '0, ram_nc_info = '0;
    logic [INFO_W-1:0] flash_sb_info = '0, flash_nc_info = '0;
    logic              irq, ram_err_rsp, flash_err_rsp;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    ecc_event_reporter dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ram_sb_evt(ram_sb_evt), .ram_sb_info(ram_sb_info),
        .ram_nc_evt(ram_nc_evt), .ram_nc_info(ram_nc_info),
        .flash_sb_evt(flash_sb_evt), .flash_sb_info(flash_sb_info),
        .flash_nc_evt(flash_nc_evt), .flash_nc_info(flash_nc_info),
        .irq(irq), .ram_err_rsp(ram_err_rsp), .flash_err_rsp(flash_err_rsp)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        bus_addr = REG_AW'(a);
        #1 d = bus_rdata;
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = REG_AW'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // ev bit 0 RAM single-bit, 1 flash single-bit, 2 RAM uncorrectable, 3 flash uncorrectable
    task automatic pulse(input logic [3:0] ev);
        @(negedge clk);
        ram_sb_evt = ev[0]; flash_sb_evt = ev[1];
        ram_nc_evt = ev[2]; flash_nc_evt = ev[3];
        @(negedge clk);
        ram_sb_evt = 1'b0; flash_sb_evt = 1'b0;
        ram_nc_evt = 1'b0; flash_nc_evt = 1'b0;
    endtask

    function automatic logic [INFO_W-1:0] mk(input int k, input int tag);
        return {32'hA000_0000 + 32'(k * 16 + tag), 8'(k * 3 + tag * 41),
                4'(k + tag * 5), 32'h5000_0000 ^ 32'(k << 8) ^ 32'(tag * 7 + 1)};
    endfunction

    task automatic chk_bank(input string req, input int base, input logic [INFO_W-1:0] e);
        logic [31:0] v;
        rd(base, v);     chk(req, v, e[75:44]);
        rd(base + 1, v); chk(req, v, {20'b0, e[35:32], e[43:36]});
        rd(base + 2, v); chk(req, v, e[31:0]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [INFO_W-1:0] exp_ram, exp_fl;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: reset state
        for (int a = 0; a < 8; a++) begin
            rd(a, v); chk("R2 reset reg", v, 32'h0);
        end
        chk("R2 reset irq", {31'b0, irq}, 32'h0);
        chk("R2 reset err", {30'b0, ram_err_rsp, flash_err_rsp}, 32'h0);

        // R1: reserved bits
        wr(0, 32'hFFFF_FFFF);
        rd(0, v); chk("R1 cfg all ones", v, 32'h0000_00F0);
        wr(0, 32'h0000_000F);
        rd(0, v); chk("R1 cfg reserved only", v, 32'h0);

        // R3/R4/R7/R8: sweep all enables x all event combinations
        exp_ram = '0; exp_fl = '0;
        for (int cfg = 0; cfg < 16; cfg++) begin
            for (int ev = 0; ev < 16; ev++) begin
                int k;
                logic [3:0] c4, e4;
                k  = cfg * 16 + ev;
                c4 = 4'(cfg); e4 = 4'(ev);
                wr(1, 32'hF);
                wr(0, {24'b0, c4, 4'b0});
                ram_sb_info = mk(k, 0); flash_sb_info = mk(k, 1);
                ram_nc_info = mk(k, 2); flash_nc_info = mk(k, 3);
                if (e4[2] && c4[2])      exp_ram = ram_nc_info;
                else if (e4[0] && c4[0]) exp_ram = ram_sb_info;
                if (e4[3] && c4[3])      exp_fl = flash_nc_info;
                else if (e4[1] && c4[1]) exp_fl = flash_sb_info;
                pulse(e4);
                chk("R10 ram err rsp", {31'b0, ram_err_rsp}, {31'b0, e4[2]});
                chk("R10 flash err rsp", {31'b0, flash_err_rsp}, {31'b0, e4[3]});
                rd(1, v); chk("R3 R4 status", v, {28'b0, e4 & c4});
                chk("R6 R4 irq", {31'b0, irq}, {31'b0, |(e4 & c4)});
                chk_bank("R7 R8 R4 ram bank", 2, exp_ram);
                chk_bank("R7 R8 R4 flash bank", 5, exp_fl);
            end
        end

        // R5/R6: write-one-to-clear and interrupt hold
        wr(1, 32'hF);
        wr(0, 32'hF0);
        pulse(4'b0001);
        pulse(4'b1000);
        rd(1, v); chk("R5 flags set", v, 32'h9);
        wr(1, 32'h0);
        rd(1, v); chk("R5 write zero no effect", v, 32'h9);
        wr(1, 32'h1);
        rd(1, v); chk("R5 clear one bit", v, 32'h8);
        chk("R6 irq held with one flag", {31'b0, irq}, 32'h1);
        wr(1, 32'h8);
        rd(1, v); chk("R5 all cleared", v, 32'h0);
        chk("R6 irq low when clear", {31'b0, irq}, 32'h0);

        // R5: set beats clear in the same cycle
        pulse(4'b0010);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = REG_AW'(1); bus_wdata = 32'h2; flash_sb_evt = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; flash_sb_evt = 1'b0;
        rd(1, v); chk("R5 set wins over clear", v, 32'h2);

        // R9: later event overwrites the bank
        ram_sb_info = mk(900, 0);
        pulse(4'b0001);
        ram_sb_info = mk(901, 0);
        pulse(4'b0001);
        chk_bank("R9 ram overwrite", 2, mk(901, 0));
        flash_nc_info = mk(902, 3);
        pulse(4'b1000);
        flash_nc_info = mk(903, 3);
        pulse(4'b1000);
        chk_bank("R9 flash overwrite", 5, mk(903, 3));

        // R10: error response with reporting disabled lasts one cycle
        wr(0, 32'h0);
        pulse(4'b0100);
        chk("R10 err while disabled", {31'b0, ram_err_rsp}, 32'h1);
        @(negedge clk);
        chk("R10 err one cycle", {31'b0, ram_err_rsp}, 32'h0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule